// File: doc/BRIEF.md
# Configurable Stereo Audio Frame Serializer

The block is the transmit half of a master-mode serial audio port. It takes a left/right pair of sample words over a valid/ready stream and serializes the pair onto three wires: a bit clock, a word-select line and a serial data line. The bit clock comes from the system clock through a fixed divider. One stereo pair fills one frame. A frame is two channel slots of `SLOT_W` bit periods each, and every sample is sent MSB first.

Two control bits choose the framing. The short-sync bit turns word-select into a one-bit-period pulse at the start of each frame. The MSB-shift bit delays the data by one bit period relative to word-select. Together they give the common variants:
- Philips: long sync, shifted data.
- Left-justified, also called PCM-long: long sync, unshifted data.
- PCM-short: pulse sync, unshifted data.

A right-first option swaps the slot order. A DAC-feed mode forces right-first order and unshifted long-sync framing, and keeps only the eight most significant bits of each sample. The configuration is sampled once per frame, at frame start. If no sample is waiting at that moment, the frame is filled with zeros and an underrun flag stays high for that frame.

Back-pressure rules: `s_ready` is high for exactly one system clock per frame, in the cycle just before the frame's first bit period. A pair is taken when `s_valid` and `s_ready` are both high on a rising clock edge. A producer that raises `s_valid` must hold the pair stable until that edge, which can be up to one full frame later.

Top module: `i2s_frame_tx`

## Requirements
- R1: The bit clock has a period of 2*HALF_DIV system clocks, low for the first HALF_DIV and high for the last HALF_DIV. It runs continuously from reset.
- R2: A frame is 2*SLOT_W bit periods. `ws` and `sd` change only at a falling edge of `bck`. With short-sync at 0, `ws` is 0 for the first slot and 1 for the second.
- R3: `s_ready` is high for exactly one system clock per frame, in the last cycle before the frame's first bit period. It never rises twice in a row. A pair is transferred only when it is accepted with `s_valid` high.
- R4: With MSB-shift at 1 (Philips), every data bit appears one bit period later than in R5. Bit period 0 of a frame carries the last data bit of the previous frame.
- R5: With MSB-shift at 0 (left-justified and PCM-long), the MSB of each slot's sample appears in the slot's first bit period.
- R6: With short-sync at 1 (PCM-short), `ws` is 1 only during bit period 0 of the frame.
- R7: `cfg_width` code n (0 to 3) selects a sample width of 8*(n+1) bits, taken from the low bits of the input word. Input bits above that width are ignored. Slot positions past the sample are sent as 0.
- R8: The first slot carries `s_left` unless `cfg_right_first` is 1, in which case the first slot carries `s_right`.
- R9: With `cfg_dac_mode` at 1, short-sync and MSB-shift are treated as 0 and right-first as 1. Only the top 8 bits of the selected-width sample are sent, in slot positions 0 to 7, and the rest of the slot is 0.
- R10: If `s_valid` is low at a frame start, every data bit of that frame is 0 and `underrun` is 1 for the whole frame. `underrun` returns to 0 at the next frame that receives a pair.
- R11: Configuration inputs are sampled only at frame start. Changes made during a frame have no effect on that frame.
- R12: While `rst_n` is low, `bck`, `ws`, `sd`, `s_ready` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Stereo pair offered |
| s_ready | output | 1 | Pair accepted this cycle (one pulse per frame) |
| s_left | input | SLOT_W | Left sample, right-justified in the word |
| s_right | input | SLOT_W | Right sample, right-justified in the word |
| cfg_width | input | 2 | Sample width code: 0=8, 1=16, 2=24, 3=32 bits |
| cfg_short_sync | input | 1 | 1: one-bit frame-sync pulse; 0: word-select held per slot |
| cfg_msb_shift | input | 1 | 1: data delayed one bit period after word-select |
| cfg_right_first | input | 1 | 1: right sample occupies the first slot |
| cfg_dac_mode | input | 1 | 1: DAC-feed mode (8 MSBs, right first, no shift, long sync) |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Current frame had no sample and carries zeros |

## Verification
The bound assertions check, on every cycle, the exact high and low length of the bit clock, that word-select and data move only on its falling edge, that the ready pulse is a single cycle that lands while the bit clock is high, and that a short-sync frame never holds word-select across two bit periods. The actual bit order, the one-period delay in shifted mode, the width truncation, the slot swap, the DAC-mode overrides, zero fill on underrun and the timing of configuration sampling depend on sample contents and history. Only the bench's reference model shows these, comparing every output pin each cycle across frames in each framing variant, idle gaps and a configuration changed in the middle of a frame.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  localparam int BYTE_BITS = 8;
  localparam int DAC_KEEP  = 8;

  typedef struct packed {
    logic       short_sync;
    logic       msb_shift;
    logic       right_first;
    logic       dac_mode;
    logic [1:0] width_sel;
  } ser_cfg_t;

  // DAC-feed mode overrides the framing bits
  function automatic ser_cfg_t effective_cfg(ser_cfg_t raw);
    ser_cfg_t e;
    e = raw;
    if (raw.dac_mode) begin
      e.short_sync  = 1'b0;
      e.msb_shift   = 1'b0;
      e.right_first = 1'b1;
    end
    return e;
  endfunction

endpackage

// File: rtl/i2s_ser_bclk.sv
module i2s_ser_bclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bck,
  output logic tick
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int DIV_W  = $clog2(PERIOD);
  localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(PERIOD - 1);
  localparam logic [DIV_W-1:0] HIGH_AT  = DIV_W'(HALF_DIV);

  logic [DIV_W-1:0] div_q;

  assign tick = (div_q == LAST_DIV);
  assign bck  = (div_q >= HIGH_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/i2s_ser_seq.sv
module i2s_ser_seq #(
  parameter int SLOT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic s_valid,
  input  logic cfg_short,
  input  logic cfg_shift,
  output logic frame_start,
  output logic ws,
  output logic frm_short,
  output logic frm_shift,
  output logic underrun
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] SLOT_EDGE = BIT_W'(SLOT_W);

  logic [BIT_W-1:0] bit_q, next_bit;
  logic             next_short, ws_next;

  assign frame_start = tick && (bit_q == LAST_BIT);
  assign next_bit    = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
  assign next_short  = frame_start ? cfg_short : frm_short;
  assign ws_next     = next_short ? (next_bit == '0) : (next_bit >= SLOT_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= LAST_BIT;
      ws        <= 1'b0;
      frm_short <= 1'b0;
      frm_shift <= 1'b0;
      underrun  <= 1'b0;
    end else if (tick) begin
      bit_q <= next_bit;
      ws    <= ws_next;
      if (frame_start) begin
        frm_short <= cfg_short;
        frm_shift <= cfg_shift;
        underrun  <= !s_valid;
      end
    end
  end
endmodule

// File: rtl/i2s_ser_pack.sv
module i2s_ser_pack #(
  parameter int SLOT_W = 32
) (
  input  logic                  valid,
  input  logic [SLOT_W-1:0]     s_left,
  input  logic [SLOT_W-1:0]     s_right,
  input  logic [1:0]            width_sel,
  input  logic                  right_first,
  input  logic                  dac_mode,
  output logic [2*SLOT_W-1:0]   frame_bits
);
  import i2s_ser_pkg::*;
  localparam int FRAME_BITS = 2 * SLOT_W;

  // left-justify the selected-width sample inside one slot
  function automatic logic [SLOT_W-1:0] pack_slot(logic [SLOT_W-1:0] smp,
                                                  logic [1:0] wsel, logic dac);
    logic [SLOT_W-1:0] res;
    int w, keep;
    res  = '0;
    w    = (int'(wsel) + 1) * BYTE_BITS;
    if (w > SLOT_W) w = SLOT_W;
    keep = dac ? DAC_KEEP : w;
    if (keep > w) keep = w;
    for (int p = 0; p < SLOT_W; p++) begin
      if (p < keep) res[SLOT_W-1-p] = smp[w-1-p];
    end
    return res;
  endfunction

  logic [SLOT_W-1:0] chan [2];
  assign chan[0] = right_first ? s_right : s_left;
  assign chan[1] = right_first ? s_left  : s_right;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign frame_bits[FRAME_BITS-1-s*SLOT_W -: SLOT_W] =
      valid ? pack_slot(chan[s], width_sel, dac_mode) : '0;
  end
endmodule

// File: rtl/i2s_ser_shift.sv
module i2s_ser_shift #(
  parameter int SLOT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic [2*SLOT_W-1:0] frame_bits,
  input  logic                use_shift,
  output logic                sd
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int TOP        = FRAME_BITS - 1;

  logic [FRAME_BITS-1:0] sr_q;
  logic                  cur_q, prev_q;

  assign sd = use_shift ? prev_q : cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (tick) begin
      prev_q <= cur_q;
      if (load) begin
        cur_q <= frame_bits[TOP];
        sr_q  <= {frame_bits[TOP-1:0], 1'b0};
      end else begin
        cur_q <= sr_q[TOP];
        sr_q  <= {sr_q[TOP-1:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx #(
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SLOT_W-1:0] s_left,
  input  logic [SLOT_W-1:0] s_right,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_short_sync,
  input  logic              cfg_msb_shift,
  input  logic              cfg_right_first,
  input  logic              cfg_dac_mode,
  output logic              bck,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);
  import i2s_ser_pkg::*;

  ser_cfg_t              cfg_raw, cfg_eff;
  logic                  tick, frame_start, frm_short, frm_shift;
  logic [2*SLOT_W-1:0]   frame_bits;

  assign cfg_raw = '{short_sync:  cfg_short_sync,
                     msb_shift:   cfg_msb_shift,
                     right_first: cfg_right_first,
                     dac_mode:    cfg_dac_mode,
                     width_sel:   cfg_width};
  assign cfg_eff = effective_cfg(cfg_raw);
  assign s_ready = frame_start;

  i2s_ser_bclk #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .bck(bck), .tick(tick)
  );

  i2s_ser_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .s_valid(s_valid),
    .cfg_short(cfg_eff.short_sync), .cfg_shift(cfg_eff.msb_shift),
    .frame_start(frame_start), .ws(ws),
    .frm_short(frm_short), .frm_shift(frm_shift), .underrun(underrun)
  );

  i2s_ser_pack #(.SLOT_W(SLOT_W)) u_pack (
    .valid(s_valid), .s_left(s_left), .s_right(s_right),
    .width_sel(cfg_eff.width_sel), .right_first(cfg_eff.right_first),
    .dac_mode(cfg_eff.dac_mode), .frame_bits(frame_bits)
  );

  i2s_ser_shift #(.SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(frame_start),
    .frame_bits(frame_bits), .use_shift(frm_shift), .sd(sd)
  );
endmodule

// File: rtl/i2s_frame_tx_chk.sv
module i2s_frame_tx_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic bck,
  input logic ws,
  input logic sd,
  input logic s_ready,
  input logic frm_short
);
  localparam int RUN_W = $clog2(HALF_DIV + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_EXP = RUN_W'(HALF_DIV);

  logic             bck_d;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d   <= 1'b0;
      run_len <= '0;
    end else begin
      bck_d   <= bck;
      run_len <= (bck != bck_d) ? RUN_W'(1) : run_len + 1'b1;
    end
  end

  AST_BCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (bck != bck_d) |-> (run_len == RUN_EXP)); // R1
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bck)); // R2
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(bck)); // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready); // R3
  AST_READY_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bck); // R3
  AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bck) && frm_short && $past(frm_short) && $past(ws)) |-> !ws); // R6
endmodule

bind i2s_frame_tx i2s_frame_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bck(bck), .ws(ws), .sd(sd),
  .s_ready(s_ready), .frm_short(frm_short)
);

// File: tb/test_i2s_frame_tx.sv
module test_i2s_frame_tx;
  localparam int SLOT = 32;
  localparam int HALF = 2;
  localparam int P    = 2 * HALF;
  localparam int FB   = 2 * SLOT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SLOT-1:0] s_left = '0, s_right = '0;
  logic [1:0] cfg_width = 2'd3;
  logic cfg_short_sync = 1'b0, cfg_msb_shift = 1'b0;
  logic cfg_right_first = 1'b0, cfg_dac_mode = 1'b0;
  logic bck, ws, sd, underrun;

  always #10 clk = ~clk;

  i2s_frame_tx #(.SLOT_W(SLOT), .HALF_DIV(HALF)) i_i2s_frame_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .cfg_width(cfg_width),
    .cfg_short_sync(cfg_short_sync), .cfg_msb_shift(cfg_msb_shift),
    .cfg_right_first(cfg_right_first), .cfg_dac_mode(cfg_dac_mode),
    .bck(bck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  int checks = 0, fails = 0;
  int cnt = 0;
  bit done = 0;
  string scen_tag = "R10";

  bit    exp_bits[$];
  bit    f_short[$], f_shift[$], f_unr[$];
  string f_tag[$];

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cnt);
    end
  endtask

  // reference: one slot of bits in transmit order
  task automatic push_slot(logic [SLOT-1:0] smp, int wsel, bit dac);
    int w, keep;
    w = 8 * (wsel + 1);
    if (w > SLOT) w = SLOT;
    keep = dac ? 8 : w;
    for (int p = 0; p < SLOT; p++)
      exp_bits.push_back((p < keep) ? smp[w-1-p] : 1'b0);
  endtask

  task automatic latch_frame();
    bit sh, sf, rf, dac, unr;
    dac = cfg_dac_mode;
    sh  = dac ? 1'b0 : cfg_short_sync;
    sf  = dac ? 1'b0 : cfg_msb_shift;
    rf  = dac ? 1'b1 : cfg_right_first;
    unr = !s_valid;
    f_short.push_back(sh);
    f_shift.push_back(sf);
    f_unr.push_back(unr);
    f_tag.push_back(unr ? "R10" : scen_tag);
    if (unr) begin
      for (int i = 0; i < FB; i++) exp_bits.push_back(1'b0);
    end else begin
      push_slot(rf ? s_right : s_left, int'(cfg_width), dac);
      push_slot(rf ? s_left : s_right, int'(cfg_width), dac);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cnt = 0;
    else begin
      if ((cnt % P == P - 1) && ((cnt / P) % FB == 0)) latch_frame();
      cnt = cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R12", "bck", bck, 1'b0);
        chk("R12", "ws", ws, 1'b0);
        chk("R12", "sd", sd, 1'b0);
        chk("R12", "s_ready", s_ready, 1'b0);
        chk("R12", "underrun", underrun, 1'b0);
      end else begin
        chk("R1", "bck", bck, (cnt % P) >= HALF);
        chk("R3", "s_ready", s_ready, (cnt % P == P - 1) && ((cnt / P) % FB == 0));
        if (cnt < P) begin
          chk("R12", "ws", ws, 1'b0);
          chk("R12", "sd", sd, 1'b0);
          chk("R12", "underrun", underrun, 1'b0);
        end else begin
          int g, f, pos;
          bit ews, esd;
          g   = cnt / P - 1;
          f   = g / FB;
          pos = g % FB;
          ews = f_short[f] ? (pos == 0) : (pos >= SLOT);
          if (f_shift[f]) esd = (g == 0) ? 1'b0 : exp_bits[g-1];
          else            esd = exp_bits[g];
          chk({"R2 ", f_tag[f]}, "ws", ws, ews);
          chk(f_tag[f], "sd", sd, esd);
          chk("R10", "underrun", underrun, f_unr[f]);
        end
      end
    end
  end

  task automatic set_cfg(int wsel, bit sh, bit sf, bit rf, bit dac);
    cfg_width = 2'(wsel);
    cfg_short_sync = sh;
    cfg_msb_shift = sf;
    cfg_right_first = rf;
    cfg_dac_mode = dac;
  endtask

  // hold the pair until the ready pulse, then drop valid
  task automatic send(logic [SLOT-1:0] l, logic [SLOT-1:0] r);
    s_left = l;
    s_right = r;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);            // first frame starts idle: R10
    scen_tag = "R4";  set_cfg(1, 0, 1, 0, 0);
    send(32'h0000_B3C5, 32'h0000_4E17);
    send(32'h0000_FFFF, 32'h0000_8001);
    scen_tag = "R5/R7"; set_cfg(2, 0, 0, 0, 0);   // 24-bit, upper byte is junk
    send(32'hFFA5_5A3C, 32'h7712_3481);
    scen_tag = "R5";  set_cfg(3, 0, 0, 0, 0);
    send(32'h8765_4321, 32'h0F1E_2D3C);
    scen_tag = "R6";  set_cfg(1, 1, 0, 0, 0);
    send(32'h0000_C0DE, 32'h0000_1357);
    send(32'h0000_7FFE, 32'h0000_0001);
    scen_tag = "R8/R4"; set_cfg(3, 0, 1, 1, 0);
    send(32'hDEAD_BEEF, 32'h1234_5678);
    scen_tag = "R7";  set_cfg(0, 0, 0, 0, 0);
    send(32'hABCD_EF96, 32'h1122_3369);
    scen_tag = "R9";  set_cfg(1, 1, 1, 0, 1);     // framing bits must be overridden
    send(32'h0000_A5F0, 32'h0000_3CE1);
    set_cfg(3, 1, 1, 0, 1);
    send(32'hC3FF_FFFF, 32'h5AFF_FFFF);
    repeat (2 * FB * P) @(negedge clk);     // idle gap: R10
    scen_tag = "R11"; set_cfg(1, 0, 1, 0, 0);
    send(32'h0000_9A6B, 32'h0000_2C4D);
    set_cfg(3, 1, 0, 1, 1);                 // mid-frame change must not apply
    repeat (100) @(negedge clk);
    set_cfg(1, 0, 1, 0, 0);
    send(32'h0000_F00F, 32'h0000_0FF0);
    scen_tag = "R4";
    send(32'h0000_0001, 32'h0000_8000);
    repeat (3 * FB * P) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule